// File: doc/BRIEF.md
# Floating-Point NaN Result Selector

This block sits beside a single-precision arithmetic datapath. It decides when the normal arithmetic result must be replaced by a NaN or an invalid-operation constant, and it raises the invalid-exception flag. Each issued operation supplies the following inputs:

- an operation class: two-source, fused three-operand, or comparison;
- the two source operands;
- the accumulator operand, used by the fused multiply-add and multiply-subtract forms;
- the invalid-condition indication from the datapath.

The block returns an override-valid bit, the 32-bit override word and the invalid flag. The result is registered one cycle behind the issue strobe.

The selection follows fixed priorities. In the fused forms, a NaN accumulator wins over both sources. Between the two sources, a signalling NaN wins over a quiet NaN, and the second source wins a tie between NaNs of the same kind. An invalid operation with no NaN input yields 0x7FFFFFFF. Comparison results are never overridden.

Top module: `fpnan_result_sel`

## Requirements
- R1: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are non-zero. The NaN is quiet when bit 22 is 1 and signalling when bit 22 is 0. Quieting sets bit 22 and leaves all other bits unchanged.
- R2: For the two-source class (op_class_i = 2'b00), when one source is a signalling NaN and the other a quiet NaN, the result is the signalling one, quieted.
- R3: When both sources are signalling NaNs, the result is src2 quieted.
- R4: When both sources are quiet NaNs, the result is src2 unchanged.
- R5: When exactly one source is a NaN, the result is that NaN, quieted if it was signalling.
- R6: When no considered operand is a NaN and dp_invalid_i is high, the result is 0x7FFFFFFF with the override bit set.
- R7: For the fused class (op_class_i = 2'b01), a NaN accumulator gives the accumulator as the result, quieted if signalling, whatever the sources hold.
- R8: For the fused class with a non-NaN accumulator, the source rules R2 to R6 apply to src1 and src2.
- R9: For the two arithmetic classes, invalid_o is high when any of src1, src2 or (fused only) dest is a signalling NaN, or when dp_invalid_i is high.
- R10: For the arithmetic classes, when no considered operand is a NaN and dp_invalid_i is low, ovr_valid_o is 0 and result_o is 0.
- R11: For the comparison class (op_class_i = 2'b10 or 2'b11), ovr_valid_o, result_o and invalid_o are all 0, whatever the operand values.
- R12: Inputs are captured on a clock edge with in_valid_i high, and out_valid_o is high for the cycle that follows. out_valid_o is low after a cycle without in_valid_i and while rst_ni is low.
- R13: Every override word is a quiet NaN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation issue strobe |
| op_class_i | input | 2 | 00 two-source, 01 fused, 1x comparison |
| src1_i | input | 32 | First source operand |
| src2_i | input | 32 | Second source operand |
| dest_i | input | 32 | Accumulator operand (fused class) |
| dp_invalid_i | input | 1 | Invalid condition from the datapath |
| out_valid_o | output | 1 | Registered result valid |
| ovr_valid_o | output | 1 | Result must replace the datapath result |
| result_o | output | 32 | Override word |
| invalid_o | output | 1 | Invalid-operation exception |

## Verification
Selection errors in this block appear at the outputs in the cycle after issue. A swapped priority between the sources, or between the accumulator and the sources, shows up only when both competing operands are NaNs. A missed quieting shows up as bit 22 clear in the result. For this reason the stimulus mixes signalling NaNs, quiet NaNs, infinities and numbers in every operand slot, so that every pairing occurs many times. A stuck output register would show on the next issue, or on an idle cycle that follows an issue.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned QBIT   = FRAC_W - 1;
  localparam logic [WORD_W-1:0] INVALID_WORD = 32'h7FFF_FFFF;

  typedef enum logic [1:0] {
    OPC_BINARY = 2'b00,
    OPC_FUSED  = 2'b01,
    OPC_CMP    = 2'b10,
    OPC_CMP_X  = 2'b11
  } op_class_e;

  typedef struct packed {
    logic              ovr;
    logic [WORD_W-1:0] word;
    logic              inv;
  } sel_res_t;

  function automatic logic is_nan(input logic [WORD_W-1:0] w);
    return (&w[WORD_W-2 -: EXP_W]) && (|w[FRAC_W-1:0]);
  endfunction

  function automatic logic is_snan(input logic [WORD_W-1:0] w);
    return is_nan(w) && !w[QBIT];
  endfunction

  function automatic logic [WORD_W-1:0] quieten(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[QBIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify
  import fpnan_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              nan_o,
  output logic              snan_o,
  output logic [WORD_W-1:0] quiet_o
);
  assign nan_o   = is_nan(word_i);
  assign snan_o  = is_snan(word_i);
  assign quiet_o = quieten(word_i);
endmodule

// File: rtl/fpnan_pair_pick.sv
module fpnan_pair_pick
  import fpnan_pkg::*;
(
  input  logic              a_nan_i,
  input  logic              a_snan_i,
  input  logic [WORD_W-1:0] a_quiet_i,
  input  logic              b_nan_i,
  input  logic              b_snan_i,
  input  logic [WORD_W-1:0] b_quiet_i,
  output logic              any_nan_o,
  output logic [WORD_W-1:0] word_o
);
  // src2 (b) wins ties; signalling beats quiet
  always_comb begin
    any_nan_o = a_nan_i | b_nan_i;
    word_o    = '0;
    if (a_nan_i && b_nan_i) begin
      if (a_snan_i && !b_snan_i) word_o = a_quiet_i;
      else                       word_o = b_quiet_i;
    end else if (a_nan_i) begin
      word_o = a_quiet_i;
    end else if (b_nan_i) begin
      word_o = b_quiet_i;
    end
  end

  always_comb begin
    if (any_nan_o) assert (word_o[QBIT] && (&word_o[WORD_W-2 -: EXP_W]))  // R13
      else $error("AST_PAIR_QUIET");
  end
endmodule

// File: rtl/fpnan_result_sel.sv
module fpnan_result_sel
  import fpnan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        op_class_i,
  input  logic [WORD_W-1:0] src1_i,
  input  logic [WORD_W-1:0] src2_i,
  input  logic [WORD_W-1:0] dest_i,
  input  logic              dp_invalid_i,
  output logic              out_valid_o,
  output logic              ovr_valid_o,
  output logic [WORD_W-1:0] result_o,
  output logic              invalid_o
);
  localparam int unsigned N_OPND = 3;

  logic [WORD_W-1:0] opnd    [N_OPND];
  logic [WORD_W-1:0] q_word  [N_OPND];
  logic [N_OPND-1:0] nan_v, snan_v;

  assign opnd[0] = src1_i;
  assign opnd[1] = src2_i;
  assign opnd[2] = dest_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_cls
    fpnan_classify u_cls (
      .word_i (opnd[g]),
      .nan_o  (nan_v[g]),
      .snan_o (snan_v[g]),
      .quiet_o(q_word[g])
    );
  end

  logic              pair_nan;
  logic [WORD_W-1:0] pair_word;

  fpnan_pair_pick u_pair (
    .a_nan_i  (nan_v[0]),
    .a_snan_i (snan_v[0]),
    .a_quiet_i(q_word[0]),
    .b_nan_i  (nan_v[1]),
    .b_snan_i (snan_v[1]),
    .b_quiet_i(q_word[1]),
    .any_nan_o(pair_nan),
    .word_o   (pair_word)
  );

  op_class_e cls;
  sel_res_t  nxt;
  assign cls = op_class_e'(op_class_i);

  always_comb begin
    nxt = '0;
    unique case (cls)
      OPC_BINARY, OPC_FUSED: begin
        nxt.inv = snan_v[0] | snan_v[1] | dp_invalid_i |
                  ((cls == OPC_FUSED) & snan_v[2]);
        if ((cls == OPC_FUSED) && nan_v[2]) begin
          nxt.ovr  = 1'b1;
          nxt.word = q_word[2];
        end else if (pair_nan) begin
          nxt.ovr  = 1'b1;
          nxt.word = pair_word;
        end else if (dp_invalid_i) begin
          nxt.ovr  = 1'b1;
          nxt.word = INVALID_WORD;
        end
      end
      default: nxt = '0;  // comparison results pass untouched
    endcase
  end

  sel_res_t res_q;
  logic     vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) res_q <= nxt;
    end
  end

  assign out_valid_o = vld_q;
  assign ovr_valid_o = res_q.ovr;
  assign result_o    = res_q.word;
  assign invalid_o   = res_q.inv;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);  // R12
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);  // R12
  AST_NO_OVR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !ovr_valid_o) |-> (result_o == '0));  // R10
  AST_OVR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ovr_valid_o) |-> (result_o[QBIT] && (&result_o[WORD_W-2 -: EXP_W])));  // R13
  AST_INV_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && invalid_o) |-> ovr_valid_o);  // R9
  AST_CMP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_class_i[1]) |=> (!ovr_valid_o && !invalid_o));  // R11
endmodule

// File: tb/fpnan_result_sel_test.sv
`timescale 1ns/1ps
module fpnan_result_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_class = 2'b00;
  logic [31:0] src1 = '0, src2 = '0, dest = '0;
  logic        dp_inv = 1'b0;
  logic        out_valid, ovr_valid, invalid;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fpnan_result_sel uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_class_i(op_class),
    .src1_i(src1), .src2_i(src2), .dest_i(dest), .dp_invalid_i(dp_inv),
    .out_valid_o(out_valid), .ovr_valid_o(ovr_valid), .result_o(result),
    .invalid_o(invalid)
  );

  function automatic bit f_nan(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction
  function automatic bit f_snan(input logic [31:0] w);
    return f_nan(w) && (w[22] == 1'b0);
  endfunction
  function automatic logic [31:0] f_q(input logic [31:0] w);
    return w | 32'h0040_0000;
  endfunction

  // expected {ovr, word, inv}
  function automatic logic [33:0] f_ref(input logic [1:0] c, input logic [31:0] a,
                                         input logic [31:0] b, input logic [31:0] d,
                                         input bit dpi);
    logic [31:0] w;
    bit o, iv;
    if (c[1]) return '0;
    iv = f_snan(a) || f_snan(b) || dpi || (c == 2'b01 && f_snan(d));
    o = 1'b1;
    if (c == 2'b01 && f_nan(d))              w = f_q(d);
    else if (f_snan(a) && f_nan(b) && !f_snan(b)) w = f_q(a);
    else if (f_nan(b))                       w = f_q(b);
    else if (f_nan(a))                       w = f_q(a);
    else if (dpi)                            w = 32'h7FFF_FFFF;
    else begin o = 1'b0; w = '0; end
    return {o, w, iv};
  endfunction

  function automatic logic [31:0] f_opnd(input int unsigned kind);
    logic [31:0] w;
    w = $urandom;
    case (kind % 5)
      0: begin w[30:23] = 8'hFF; w[22] = 1'b0; if (w[21:0] == 0) w[0] = 1'b1; end
      1: begin w[30:23] = 8'hFF; w[22] = 1'b1; end
      2: w[30:0] = {8'hFF, 23'h0};
      default: if (w[30:23] == 8'hFF) w[30:23] = 8'h7F;
    endcase
    return w;
  endfunction

  task automatic check(input string tag, input logic [33:0] exp_v);
    n_checks++;
    if (out_valid !== 1'b1 || {ovr_valid, result, invalid} !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got vld=%b ovr=%b res=%h inv=%b exp ovr=%b res=%h inv=%b",
               tag, out_valid, ovr_valid, result, invalid, exp_v[33], exp_v[32:1], exp_v[0]);
    end
  endtask

  task automatic issue(input string tag, input logic [1:0] c, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] d, input bit dpi);
    in_valid = 1'b1; op_class = c; src1 = a; src2 = b; dest = d; dp_inv = dpi;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, f_ref(c, a, b, d, dpi));
  endtask

  localparam logic [31:0] SN1 = 32'h7F80_0011, SN2 = 32'hFF82_0000;
  localparam logic [31:0] QN1 = 32'h7FC0_0001, QN2 = 32'hFFE0_0002;
  localparam logic [31:0] NUM = 32'h3F80_0000;

  initial begin
    void'($urandom(32'd1146));
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || ovr_valid !== 1'b0 || result !== '0 || invalid !== 1'b0) begin
      n_fail++;
      $display("FAIL R12 reset: vld=%b ovr=%b res=%h inv=%b exp all zero",
               out_valid, ovr_valid, result, invalid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    issue("R2 snan1/qnan2", 2'b00, SN1, QN2, 0, 0);
    issue("R2 qnan1/snan2", 2'b00, QN1, SN2, 0, 0);
    issue("R3 both snan", 2'b00, SN1, SN2, 0, 0);
    issue("R4 both qnan", 2'b00, QN1, QN2, 0, 0);
    issue("R5 snan1/num", 2'b00, SN1, NUM, 0, 0);
    issue("R5 num/qnan2", 2'b00, NUM, QN2, 0, 1);
    issue("R6 invalid no nan", 2'b00, NUM, NUM, 0, 1);
    issue("R10 clean", 2'b00, NUM, 32'h0, 0, 0);
    issue("R7 qnan dest", 2'b01, SN1, SN2, QN1, 0);
    issue("R7 snan dest", 2'b01, NUM, NUM, SN2, 0);
    issue("R8 num dest", 2'b01, QN1, SN2, NUM, 0);
    issue("R9 fused snan dest inv", 2'b01, NUM, NUM, SN1, 0);
    issue("R9 binary dest ignored", 2'b00, NUM, NUM, SN1, 0);
    issue("R11 compare", 2'b10, SN1, SN2, QN1, 1);
    issue("R11 compare x", 2'b11, NUM, QN1, NUM, 0);
    issue("R1 min snan frac", 2'b00, 32'h7F80_0001, NUM, 0, 0);
    issue("R1 inf not nan", 2'b00, 32'h7F80_0000, 32'hFF80_0000, 0, 0);

    // R12: idle cycle drops out_valid
    @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R12 idle: vld=%b exp 0", out_valid);
    end

    for (int i = 0; i < 3000; i++) begin
      issue("R13 random", 2'($urandom), f_opnd($urandom), f_opnd($urandom),
            f_opnd($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule